// File: doc/BRIEF.md
# Serial ADC Interface Responder

This block plays the converter side of a three-wire serial ADC link so that a controller design can be exercised against a synthesizable counterpart. A conversion starts when the active-low start strobe falls. At that moment the block captures a 12-bit sample word. Each rising edge of the serial clock then moves the next bit of a 16-bit frame onto the data line: three leading zeros, the sample from its most significant bit down to bit 0, and one trailing zero.

The data line has its own output-enable. The enable depends on how many serial-clock rising edges have been counted when the strobe rises again. The same count drives a three-state power-mode machine. A strobe raised early in the frame steps the mode down from normal to partial power-down, and from partial to full power-down. Holding the strobe low for long enough brings the mode back to normal.

Both the strobe and the serial clock are sampled on the block's own system clock through a synchronizer chain. All edges are detected in that clock domain.

Top module: `adc_serial_responder`

## Requirements
- R1: After reset the power mode is normal, the output enable is low and the data output is low.
- R2: A falling edge of the strobe captures the sample input, clears the edge count, drives the output enable high and drives the data output to 0.
- R3: After the k-th serial-clock rising edge since the strobe fell, the data output presents frame bit k. For k from 1 to 3 and for k = 16 that bit is 0. For k from 4 to 15 it is sample bit 15-k, so k=4 gives bit 11 and k=15 gives bit 0.
- R4: Changes on the sample input after the strobe has fallen do not alter the frame being shifted out.
- R5: With the strobe still low, the 17th serial-clock rising edge releases the output: the enable goes low and the data output goes to 0.
- R6: When the strobe rises with a count of 12 or less, or 16 or more, the output is released at once. When it rises with a count of 13 to 15, shifting continues and the 17th rising edge releases the output.
- R7: In normal mode, a strobe rise with a count from 4 to 12 enters partial power-down. Any other count leaves the mode unchanged.
- R8: In partial power-down, a strobe rise with a count below 4 keeps the mode. A count from 4 to 12 enters full power-down. A count of 13 or more returns to normal. The mode changes only on a strobe rise.
- R9: In full power-down, a strobe rise with a count of 13 or more returns to normal. Any smaller count keeps full power-down.
- R10: The edge count saturates at 31. However long the strobe is held low, the hold is judged as at least 13 edges.
- R11: The mode output is encoded as 2'b00 for normal, 2'b01 for partial power-down and 2'b10 for full power-down. The value 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples strobe and serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnv_start_n | input | 1 | Conversion-start strobe, active low |
| ser_clk | input | 1 | Serial clock from the controller |
| sample_in | input | 12 | Sample word to be framed |
| ser_dout | output | 1 | Serial data, 0 while released |
| ser_dout_oe | output | 1 | Output-driver enable (high drives, low means high impedance) |
| pwr_mode | output | 2 | Current power mode |

## Verification
The bench builds the block with a two-stage synchronizer, a 5-bit edge counter and the default 3 + 12 + 1 frame layout. Each serial-clock phase is held for six system clocks, which covers the detection latency.

The 5-bit counter puts saturation at 31, so a 40-edge hold is enough to expose a counter that wraps to 8. A wrapped count would land in the power-down window instead of returning to normal. The frame layout lets every boundary count be driven with short strobe pulses: 3, 4, 12, 13, 14, 16 and 17 edges.

// File: rtl/adcr_pkg.sv
package adcr_pkg;

    typedef enum logic [1:0] {
        PM_NORMAL  = 2'b00,
        PM_PARTIAL = 2'b01,
        PM_FULL    = 2'b10
    } pwr_mode_e;

    // How long the strobe stayed low, judged at its rising edge
    typedef enum logic [1:0] {
        HOLD_EARLY  = 2'b00,
        HOLD_WINDOW = 2'b01,
        HOLD_LONG   = 2'b10
    } hold_cls_e;

endpackage

// File: rtl/adcr_edge_sync.sv
module adcr_edge_sync #(
    parameter int   STAGES    = 2,
    parameter logic RST_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);

    typedef struct packed {
        logic [STAGES-1:0] pipe;
        logic              prev;
    } sync_st_t;

    sync_st_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.pipe = (st_q.pipe << 1) | STAGES'(din);
        st_d.prev = st_q.pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pipe <= {STAGES{RST_LEVEL}};
            st_q.prev <= RST_LEVEL;
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.pipe[STAGES-1];
    assign rise  = level & ~st_q.prev;
    assign fall  = ~level & st_q.prev;

endmodule

// File: rtl/adcr_edge_count.sv
module adcr_edge_count #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] LIMIT = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (inc && st_q.cnt != LIMIT) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;

endmodule

// File: rtl/adcr_frame_shift.sv
module adcr_frame_shift #(
    parameter int SAMPLE_W = 12,
    parameter int LEAD     = 3,
    parameter int TRAIL    = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                advance,
    input  logic                drop,
    output logic                dout,
    output logic                oe
);

    localparam int FRAME_W = LEAD + SAMPLE_W + TRAIL;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic               bitv;
        logic               oe;
    } frm_st_t;

    frm_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (load) begin
            // leading zeros come from zero extension, trailing from the shift
            st_d.frame = FRAME_W'(sample) << TRAIL;
            st_d.bitv  = 1'b0;
            st_d.oe    = 1'b1;
        end else begin
            if (advance) begin
                st_d.bitv  = st_q.frame[FRAME_W-1];
                st_d.frame = st_q.frame << 1;
            end
            if (drop) begin
                st_d.oe = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign oe   = st_q.oe;
    assign dout = st_q.oe & st_q.bitv;

endmodule

// File: rtl/adcr_mode_fsm.sv
module adcr_mode_fsm
    import adcr_pkg::*;
#(
    parameter int CNT_W     = 5,
    parameter int ENTER_MIN = 4,
    parameter int EXIT_MIN  = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             decide,
    input  logic [CNT_W-1:0] hold_cnt,
    output pwr_mode_e        mode
);

    localparam logic [CNT_W-1:0] ENTER_C = CNT_W'(ENTER_MIN);
    localparam logic [CNT_W-1:0] EXIT_C  = CNT_W'(EXIT_MIN);

    typedef struct packed {
        pwr_mode_e mode;
    } fsm_st_t;

    fsm_st_t   st_q, st_d;
    hold_cls_e cls;

    always_comb begin
        if (hold_cnt < ENTER_C) begin
            cls = HOLD_EARLY;
        end else if (hold_cnt < EXIT_C) begin
            cls = HOLD_WINDOW;
        end else begin
            cls = HOLD_LONG;
        end
    end

    always_comb begin
        st_d = st_q;
        if (decide) begin
            unique case (st_q.mode)
                PM_NORMAL: begin
                    if (cls == HOLD_WINDOW) st_d.mode = PM_PARTIAL;
                end
                PM_PARTIAL: begin
                    if (cls == HOLD_WINDOW)    st_d.mode = PM_FULL;
                    else if (cls == HOLD_LONG) st_d.mode = PM_NORMAL;
                end
                PM_FULL: begin
                    if (cls == HOLD_LONG) st_d.mode = PM_NORMAL;
                end
                default: st_d.mode = PM_NORMAL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= PM_NORMAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode = st_q.mode;

endmodule

// File: rtl/adc_serial_responder.sv
module adc_serial_responder
    import adcr_pkg::*;
#(
    parameter int SAMPLE_W    = 12,
    parameter int LEAD_ZEROS  = 3,
    parameter int TRAIL_ZEROS = 1,
    parameter int CNT_W       = 5,
    parameter int SYNC_STAGES = 2,
    parameter int ENTER_MIN   = 4,
    parameter int EXIT_MIN    = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cnv_start_n,
    input  logic                ser_clk,
    input  logic [SAMPLE_W-1:0] sample_in,
    output logic                ser_dout,
    output logic                ser_dout_oe,
    output logic [1:0]          pwr_mode
);

    localparam int FRAME_W = LEAD_ZEROS + SAMPLE_W + TRAIL_ZEROS;
    localparam logic [CNT_W-1:0] FRAME_C = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] EXIT_C  = CNT_W'(EXIT_MIN);

    logic             stb_level, stb_rise, stb_fall;
    logic             sck_level, sclk_rise, sck_fall;
    logic [CNT_W-1:0] cnt;
    logic             advance, drop;
    pwr_mode_e        mode_w;

    adcr_edge_sync #(.STAGES(SYNC_STAGES), .RST_LEVEL(1'b1)) u_stb_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cnv_start_n),
        .level (stb_level),
        .rise  (stb_rise),
        .fall  (stb_fall)
    );

    adcr_edge_sync #(.STAGES(SYNC_STAGES), .RST_LEVEL(1'b0)) u_sck_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ser_clk),
        .level (sck_level),
        .rise  (sclk_rise),
        .fall  (sck_fall)
    );

    adcr_edge_count #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (stb_fall),
        .inc   (sclk_rise),
        .count (cnt)
    );

    // A strobe edge takes priority over a serial-clock edge in the same cycle
    always_comb begin
        advance = sclk_rise & ~stb_fall;
        drop    = 1'b0;
        if (stb_rise) begin
            drop = (cnt < EXIT_C) || (cnt >= FRAME_C);
        end else if (advance && cnt == FRAME_C) begin
            drop = 1'b1;
        end
    end

    adcr_frame_shift #(
        .SAMPLE_W (SAMPLE_W),
        .LEAD     (LEAD_ZEROS),
        .TRAIL    (TRAIL_ZEROS)
    ) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (stb_fall),
        .sample  (sample_in),
        .advance (advance),
        .drop    (drop),
        .dout    (ser_dout),
        .oe      (ser_dout_oe)
    );

    adcr_mode_fsm #(
        .CNT_W     (CNT_W),
        .ENTER_MIN (ENTER_MIN),
        .EXIT_MIN  (EXIT_MIN)
    ) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .decide   (stb_rise),
        .hold_cnt (cnt),
        .mode     (mode_w)
    );

    assign pwr_mode = mode_w;

    logic unused_levels;
    assign unused_levels = stb_level ^ sck_level ^ sck_fall;

endmodule

// File: rtl/adcr_checker.sv
module adcr_checker
    import adcr_pkg::*;
#(
    parameter int CNT_W    = 5,
    parameter int FRAME_W  = 16,
    parameter int EXIT_MIN = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stb_rise,
    input logic             stb_fall,
    input logic             sclk_rise,
    input logic [CNT_W-1:0] cnt,
    input logic             oe,
    input logic [1:0]       mode
);

    localparam logic [CNT_W-1:0] LIM_C = '1;
    localparam logic [CNT_W-1:0] FR_C  = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] EX_C  = CNT_W'(EXIT_MIN);

    assert_enable_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stb_fall |=> (oe && cnt == '0));

    assert_release_17_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise && !stb_fall && !stb_rise && cnt == FR_C) |=> !oe);

    assert_early_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_rise && cnt < EX_C) |=> !oe);

    assert_normal_no_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_NORMAL) |=> (mode != PM_FULL));

    assert_mode_only_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_rise |=> $stable(mode));

    assert_full_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_FULL) |=> (mode != PM_PARTIAL));

    assert_count_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == LIM_C && !stb_fall) |=> (cnt == LIM_C));

    assert_mode_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'b11);

endmodule

bind adc_serial_responder adcr_checker #(
    .CNT_W    (CNT_W),
    .FRAME_W  (FRAME_W),
    .EXIT_MIN (EXIT_MIN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb_rise  (stb_rise),
    .stb_fall  (stb_fall),
    .sclk_rise (sclk_rise),
    .cnt       (cnt),
    .oe        (ser_dout_oe),
    .mode      (pwr_mode)
);

// File: tb/adc_serial_responder_tb.sv
module adc_serial_responder_tb;
    import adcr_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe = 1'b1;
    logic        sclk = 1'b0;
    logic [11:0] sample = '0;
    logic        dout, oe;
    logic [1:0]  mode;

    typedef struct packed {
        logic       oe;
        logic       dout;
        logic [1:0] mode;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_serial_responder #(
        .SAMPLE_W(12), .LEAD_ZEROS(3), .TRAIL_ZEROS(1),
        .CNT_W(5), .SYNC_STAGES(2), .ENTER_MIN(4), .EXIT_MIN(13)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnv_start_n (strobe),
        .ser_clk     (sclk),
        .sample_in   (sample),
        .ser_dout    (dout),
        .ser_dout_oe (oe),
        .pwr_mode    (mode)
    );

    // Monitor: pops each expectation as soon as it is pushed and compares
    initial begin
        exp_t  e;
        string t;
        forever begin
            wait (exp_q.size() != 0);
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (oe !== e.oe || dout !== e.dout || mode !== e.mode) begin
                n_bad++;
                $display("FAIL %s: oe/dout/mode actual %b/%b/%b expected %b/%b/%b",
                         t, oe, dout, mode, e.oe, e.dout, e.mode);
            end
        end
    end

    task automatic hold();
        repeat (HOLD) @(negedge clk);
    endtask

    task automatic expect_st(string t, logic e_oe, logic e_d, logic [1:0] e_m);
        exp_t e;
        e.oe   = e_oe;
        e.dout = e_d;
        e.mode = e_m;
        tag_q.push_back(t);
        exp_q.push_back(e);
        #1;
    endtask

    function automatic logic fbit(int k, logic [11:0] s);
        if (k >= 4 && k <= 15) return s[15-k];
        return 1'b0;
    endfunction

    // One strobe-low window with n serial-clock rising edges
    task automatic conv(int n, logic [11:0] s, logic [1:0] m0, logic [1:0] m1, string mtag);
        logic en;
        sample = s;
        strobe = 1'b0;
        hold();
        expect_st("R2", 1'b1, 1'b0, m0);
        sample = ~s;                       // R4: must not reach the frame
        en = 1'b1;
        for (int i = 1; i <= n; i++) begin
            sclk = 1'b1;
            hold();
            if (i == 17) en = 1'b0;
            expect_st(i > 16 ? "R5" : "R3,R4", en, en ? fbit(i, s) : 1'b0, m0);
            sclk = 1'b0;
            hold();
        end
        strobe = 1'b1;
        hold();
        if (n <= 12 || n >= 16) en = 1'b0;
        expect_st({"R6,", mtag}, en, en ? fbit(n, s) : 1'b0, m1);
        if (en) begin
            for (int i = n + 1; i <= 17; i++) begin
                sclk = 1'b1;
                hold();
                if (i == 17) en = 1'b0;
                expect_st("R6", en, en ? fbit(i, s) : 1'b0, m1);
                sclk = 1'b0;
                hold();
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        hold();
        expect_st("R1,R11", 1'b0, 1'b0, PM_NORMAL);

        conv(16, 12'hA5C, PM_NORMAL,  PM_NORMAL,  "R7");
        conv(17, 12'h3E1, PM_NORMAL,  PM_NORMAL,  "R7");
        conv(14, 12'hF0F, PM_NORMAL,  PM_NORMAL,  "R7");
        conv(3,  12'h801, PM_NORMAL,  PM_NORMAL,  "R7");
        conv(13, 12'h7FE, PM_NORMAL,  PM_NORMAL,  "R7");
        conv(4,  12'h555, PM_NORMAL,  PM_PARTIAL, "R7,R11");
        conv(2,  12'hAAA, PM_PARTIAL, PM_PARTIAL, "R8");
        conv(12, 12'h123, PM_PARTIAL, PM_FULL,    "R8,R11");
        conv(12, 12'h456, PM_FULL,    PM_FULL,    "R9");
        conv(3,  12'h789, PM_FULL,    PM_FULL,    "R9");
        conv(13, 12'hFFF, PM_FULL,    PM_NORMAL,  "R9");
        conv(8,  12'h0F0, PM_NORMAL,  PM_PARTIAL, "R7");
        conv(13, 12'hC3C, PM_PARTIAL, PM_NORMAL,  "R8");
        conv(6,  12'h9A6, PM_NORMAL,  PM_PARTIAL, "R7");
        conv(40, 12'h5A5, PM_PARTIAL, PM_NORMAL,  "R10");
        conv(4,  12'h001, PM_NORMAL,  PM_PARTIAL, "R2");
        conv(40, 12'h6B2, PM_PARTIAL, PM_NORMAL,  "R10");

        wait (exp_q.size() == 0);
        @(negedge clk);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual still running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule